// File: doc/BRIEF.md
# Real-time clock with queued periodic interrupt

This block is a real-time clock for a 16-bit register bus. A prescaler, stepped by a clock-enable input, produces two strobes. The one-second strobe advances a 33-bit elapsed-time counter. The base-rate strobe drives a periodic tick generator whose rate software sets by writing a divisor. Software reads the elapsed time through three 16-bit windows. The least significant time bit sits alone in bit 15 of the lowest window, so that window and the two above it join into one left-aligned 48-bit value.

Periodic ticks are not collapsed into a single flag. Each tick adds one to a saturating pending count. The interrupt output is high while that count is nonzero. Software services ticks one at a time: every access to the acknowledge register takes one tick off the count. If ticks arrive faster than the handler runs, the interrupt therefore stays asserted until every queued tick has been retired.

Top module: `rtc_tick_top`

## Requirements
- R1: After reset the time count is zero, the divisor is zero, the periodic generator is stopped, and `irq_out` is low.
- R2: The time count advances by one each time `SEC_PRE` cycles with `tick_en` high have been counted.
- R3: A read of offset 0x0C0 returns time bit 0 in data bit 15 and zero in bits 14:0. Read data appears on `bus_rdata` in the cycle after the read access and holds until the next read.
- R4: A read of offset 0x0C2 returns time bits 16:1, and a read of offset 0x0C4 returns time bits 32:17.
- R5: Writing a nonzero N to offset 0x0D0 sets the periodic interval to N base strobes, where one base strobe is `BASE_PRE` enabled cycles. A read of 0x0D0 returns the current divisor.
- R6: Writing zero to offset 0x0D0 leaves the divisor and the tick rate unchanged.
- R7: Writes to offset 0x0D2 have no effect, and reads of 0x0D2 return zero.
- R8: A new divisor takes effect only at the end of the interval already running.
- R9: Each periodic tick adds one to the pending count, and `irq_out` is high exactly while the pending count is nonzero.
- R10: Any access, read or write, to offset 0x1DE removes one tick from a nonzero pending count. When the count is zero, such an access has no effect. A read of 0x1DE returns zero.
- R11: The pending count saturates at 2^`PEND_W`-1 and does not wrap.
- R12: Reads of unmapped offsets return zero, and writes to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Clock enable that steps the prescaler |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| irq_out | output | 1 | Periodic interrupt, high while ticks are pending |

## Verification
The bench builds the block with `SEC_PRE`=1, `BASE_PRE`=3 and `PEND_W`=4. With one enabled cycle per second, about 140,000 enabled cycles carry the time count past bits 16 and 17, so all three windows show nonzero fields. The small pending width lets that same run fill and saturate the queue, and fifteen acknowledges can then drain it. A base ratio of 3 exercises the counting prescaler. Interval lengths of 12 and 6 enabled cycles expose when a new divisor is adopted.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned TIME_W = 33;

  localparam logic [ADDR_W-1:0] OFS_TIME_LO  = 12'h0C0;
  localparam logic [ADDR_W-1:0] OFS_TIME_MID = 12'h0C2;
  localparam logic [ADDR_W-1:0] OFS_TIME_HI  = 12'h0C4;
  localparam logic [ADDR_W-1:0] OFS_DIV_LO   = 12'h0D0;
  localparam logic [ADDR_W-1:0] OFS_DIV_HI   = 12'h0D2;
  localparam logic [ADDR_W-1:0] OFS_ACK      = 12'h1DE;

  function automatic logic [DATA_W-1:0] time_window(
    input logic [1:0] sel, input logic [TIME_W-1:0] t);
    case (sel)
      2'd0:    time_window = {t[0], {(DATA_W-1){1'b0}}};
      2'd1:    time_window = t[16:1];
      2'd2:    time_window = t[32:17];
      default: time_window = '0;
    endcase
  endfunction
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/rtc_strobe_div.sv
module rtc_strobe_div #(
  parameter int unsigned RATIO = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic stb
);
  localparam int unsigned CW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap = en && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (en) begin
      if (wrap) cnt_d = '0;
      else      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign stb = wrap;
endmodule

// File: rtl/rtc_time_cnt.sv
module rtc_time_cnt #(
  parameter int unsigned W = 33
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] count
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/rtc_rate_div.sv
module rtc_rate_div #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_stb,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wdata,
  output logic [DIV_W-1:0] div_value,
  output logic             tick
);
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] act_q, act_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tick_c;

  always_comb begin
    div_d = div_q;
    if (div_we && (div_wdata != '0)) div_d = div_wdata;
  end

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    tick_c = 1'b0;
    if (base_stb) begin
      if (act_q == '0) begin
        act_d = div_q;
        cnt_d = '0;
      end else if (cnt_q == act_q - 1'b1) begin
        tick_c = 1'b1;
        cnt_d  = '0;
        act_d  = div_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      act_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign div_value = div_q;
  assign tick      = tick_c;
endmodule

// File: rtl/rtc_pend_cnt.sv
module rtc_pend_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d, after_dec;

  always_comb begin
    after_dec = cnt_q;
    if (dec && (cnt_q != '0)) after_dec = cnt_q - 1'b1;
    cnt_d = after_dec;
    if (inc && (after_dec != TOP)) cnt_d = after_dec + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/rtc_tick_top.sv
module rtc_tick_top
  import rtc_pkg::*;
#(
  parameter int unsigned SEC_PRE  = 32768,
  parameter int unsigned BASE_PRE = 4,
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned PEND_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  logic              rst_n_sync;
  logic              sec_stb, base_stb, per_tick, ack, div_we, rd;
  logic [TIME_W-1:0] time_q;
  logic [DIV_W-1:0]  div_q;
  logic [PEND_W-1:0] pend_q;
  logic [DATA_W-1:0] rdata_q, rdata_d, rd_mux;

  rtc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync));

  rtc_strobe_div #(.RATIO(SEC_PRE)) u_sec_pre (
    .clk(clk), .rst_n(rst_n_sync), .en(tick_en), .stb(sec_stb));

  rtc_strobe_div #(.RATIO(BASE_PRE)) u_base_pre (
    .clk(clk), .rst_n(rst_n_sync), .en(tick_en), .stb(base_stb));

  rtc_time_cnt #(.W(TIME_W)) u_time (
    .clk(clk), .rst_n(rst_n_sync), .step(sec_stb), .count(time_q));

  assign div_we = bus_sel && bus_wr && (bus_addr == OFS_DIV_LO);
  assign ack    = bus_sel && (bus_addr == OFS_ACK);
  assign rd     = bus_sel && !bus_wr;

  rtc_rate_div #(.DIV_W(DIV_W)) u_rate (
    .clk(clk), .rst_n(rst_n_sync), .base_stb(base_stb), .div_we(div_we),
    .div_wdata(bus_wdata[DIV_W-1:0]), .div_value(div_q), .tick(per_tick));

  rtc_pend_cnt #(.W(PEND_W)) u_pend (
    .clk(clk), .rst_n(rst_n_sync), .inc(per_tick), .dec(ack), .count(pend_q));

  always_comb begin
    case (bus_addr)
      OFS_TIME_LO:  rd_mux = time_window(2'd0, time_q);
      OFS_TIME_MID: rd_mux = time_window(2'd1, time_q);
      OFS_TIME_HI:  rd_mux = time_window(2'd2, time_q);
      OFS_DIV_LO:   rd_mux = DATA_W'(div_q);
      default:      rd_mux = '0;
    endcase
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd) rdata_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = (pend_q != '0);
endmodule

// File: rtl/rtc_tick_chk.sv
module rtc_tick_chk
  import rtc_pkg::*;
#(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned PEND_W = 8
) (
  input logic              clk,
  input logic              rst_n_sync,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              sec_stb,
  input logic [TIME_W-1:0] time_q,
  input logic [DIV_W-1:0]  div_q,
  input logic              per_tick,
  input logic              ack,
  input logic [PEND_W-1:0] pend_q,
  input logic              irq_out
);
  localparam logic [PEND_W-1:0] TOP = {PEND_W{1'b1}};

  a_r2_time_holds: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !sec_stb |=> $stable(time_q));

  a_r2_time_steps: assert property (@(posedge clk) disable iff (!rst_n_sync)
    sec_stb |=> (time_q == $past(time_q) + 1'b1));

  a_r6_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (bus_sel && bus_wr && bus_addr == OFS_DIV_LO && bus_wdata == '0) |=> $stable(div_q));

  a_r7_hi_no_effect: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (bus_sel && bus_wr && bus_addr == OFS_DIV_HI) |=> $stable(div_q));

  a_r9_tick_adds: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (per_tick && !ack && pend_q != TOP) |=> (pend_q == $past(pend_q) + 1'b1));

  a_r10_ack_removes: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (ack && !per_tick && pend_q != '0) |=> (pend_q == $past(pend_q) - 1'b1));

  a_r10_ack_at_zero: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (ack && !per_tick && pend_q == '0) |=> (pend_q == '0));

  a_r11_no_wrap: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (pend_q == TOP && !ack) |=> (pend_q == TOP));

  a_r9_irq_rises: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(irq_out) |-> $past(per_tick));
endmodule

bind rtc_tick_top rtc_tick_chk #(.DIV_W(DIV_W), .PEND_W(PEND_W)) u_chk (
  .clk(clk), .rst_n_sync(rst_n_sync), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .sec_stb(sec_stb),
  .time_q(time_q), .div_q(div_q), .per_tick(per_tick), .ack(ack),
  .pend_q(pend_q), .irq_out(irq_out));

// File: tb/sim_rtc_tick_top.sv
`timescale 1ns/1ps
module sim_rtc_tick_top;
  localparam int unsigned SEC_PRE  = 1;
  localparam int unsigned BASE_PRE = 3;
  localparam int unsigned PEND_W   = 4;
  localparam int          PMAX     = (1 << PEND_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_out;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          checks = 0;
  int          errors = 0;
  longint      en_total = 0;
  logic        rd_seen = 1'b0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_tick_top #(.SEC_PRE(SEC_PRE), .BASE_PRE(BASE_PRE), .DIV_W(16), .PEND_W(PEND_W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

  always @(posedge clk) rd_seen <= bus_sel && !bus_wr;

  // monitor: pops the scoreboard when a read result is due
  always @(negedge clk) begin
    if (rd_seen) begin
      exp_t e;
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: read result with no expectation, actual=%h expected=none", bus_rdata);
      end else begin
        e = sb_q.pop_front();
        if (bus_rdata !== e.exp) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", e.tag, bus_rdata, e.exp);
        end
      end
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [15:0] exp, input string tag);
    exp_t e;
    e.exp = exp; e.tag = tag;
    sb_q.push_back(e);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_en();
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    en_total++;
  endtask

  task automatic hold_en(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
    en_total += n;
  endtask

  // counts enabled cycles until irq rises, then acknowledges the tick
  task automatic measure(output int n);
    n = 0;
    while (irq_out !== 1'b1 && n < 1000) begin
      pulse_en();
      n++;
    end
    bus_read(12'h1DE, 16'h0000, "R10 ack read data");
    check("R10 irq low after single ack", irq_out, 0);
  endtask

  task automatic read_time(input string tag);
    longint t;
    t = en_total / SEC_PRE;
    bus_read(12'h0C0, {t[0], 15'b0}, {tag, " R3 low window"});
    bus_read(12'h0C2, t[16:1], {tag, " R4 mid window"});
    bus_read(12'h0C4, t[32:17], {tag, " R4 high window"});
  endtask

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 irq after reset", irq_out, 0);
    read_time("R1 reset");
    bus_read(12'h0D0, 16'h0000, "R1 divisor after reset");

    // R1 generator stopped: enables produce no tick
    repeat (30) pulse_en();
    check("R1 no tick with zero divisor", irq_out, 0);

    // R2 time advances with enables
    repeat (5) pulse_en();
    read_time("R2 after 35");

    // R6 zero write ignored, R7 upper half ignored, R12 unmapped
    bus_write(12'h0D0, 16'h0000);
    bus_read(12'h0D0, 16'h0000, "R6 zero write ignored");
    bus_write(12'h0D2, 16'h0005);
    bus_read(12'h0D0, 16'h0000, "R7 upper write no effect");
    bus_read(12'h0D2, 16'h0000, "R7 upper reads zero");
    bus_write(12'h0D4, 16'h0007);
    bus_read(12'h0D0, 16'h0000, "R12 unmapped write ignored");
    bus_read(12'h0F0, 16'h0000, "R12 unmapped read zero");
    repeat (30) pulse_en();
    check("R6 still no tick", irq_out, 0);

    // R5 program divisor 4
    bus_write(12'h0D0, 16'h0004);
    bus_read(12'h0D0, 16'h0004, "R5 divisor readback");
    bus_write(12'h0D0, 16'h0000);
    bus_read(12'h0D0, 16'h0004, "R6 zero write keeps divisor");
    measure(n);   // first interval includes load latency
    check("R9 first tick arrives", (n < 1000) ? 1 : 0, 1);
    measure(n);
    check("R5 interval for N=4", n, BASE_PRE * 4);

    // R8 change divisor just after a boundary
    bus_write(12'h0D0, 16'h0002);
    measure(n);
    check("R8 old interval runs out", n, BASE_PRE * 4);
    measure(n);
    check("R8 new interval N=2", n, BASE_PRE * 2);

    // R10 ack at zero has no effect (write access)
    bus_write(12'h1DE, 16'hFFFF);
    check("R10 ack at zero keeps irq low", irq_out, 0);
    measure(n);
    check("R10 interval undisturbed", n, BASE_PRE * 2);

    // long run: time crosses bits 16 and 17, pending saturates
    hold_en(140001);
    read_time("R4 long run");
    check("R9 irq high with pending ticks", irq_out, 1);
    for (int i = 1; i < PMAX; i++) begin
      bus_write(12'h1DE, 16'h0000);
      check($sformatf("R11 irq after ack %0d", i), irq_out, 1);
    end
    bus_write(12'h1DE, 16'h0000);
    check("R11 irq low after max acks", irq_out, 0);
    bus_read(12'h1DE, 16'h0000, "R10 extra ack read");
    check("R10 extra ack keeps irq low", irq_out, 0);

    repeat (3) @(negedge clk);
    check("scoreboard drained", sb_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule